// File: doc/BRIEF.md
# Configuration access port translator

This block sits on the host side of a system and decodes processor I/O reads and writes into configuration-space requests. Two legacy access schemes are supported and may be enabled together. In scheme one, software loads a 32-bit address latch at I/O 0xCF8 and then moves data through a four-byte window at 0xCFC to 0xCFF. In scheme two, software writes a one-byte enable register at 0xCF8 and a one-byte bus register at 0xCFA. While the window is open, the page 0xC000 to 0xCFFF addresses configuration space directly, with the device number taken from address bits 11:8.

Each decoded access yields one configuration request that carries bus, device, function, dword register index, byte enables, cycle type and direction. The request is held until the target acknowledges it or a timeout expires. I/O accesses that neither scheme claims are marked pass-through, so the host can route them as ordinary I/O cycles. Two strap inputs select which scheme is live.

Top module: `cfg_port_xlat`

## Requirements
- R1: During and after reset the address latch, enable byte and bus byte are zero, and cfg_req_o and io_done_o are low. A dword read of 0xCF8 right after reset returns 0.
- R2: With scheme one strapped (mode1_en_i=1), a dword (io_size_i=2) write to 0xCF8 loads all 32 latch bits and a dword read returns them. Writing 0 reads back 0.
- R3: With scheme two not strapped, byte or 16-bit accesses to 0xCF8 to 0xCFB complete with io_pass_o=1 and leave the latch unchanged.
- R4: When latch bit 31 is set, an access to 0xCFC to 0xCFF issues a request with bus = latch[23:16], device = latch[15:11], function = latch[10:8], register = latch[7:2] and cfg_type1_o = latch[0]. The write data is shifted up by 8 times the address offset.
- R5: Byte enables follow size and offset: a byte (io_size_i=0) at offset n gives 1<<n, a half word (io_size_i=1) at offset 0 or 2 gives 0011 or 1100, and a dword at offset 0 gives 1111. A half word at an odd offset, or a dword that is not at offset 0, is passed through. Read data returns in lane 0, shifted down by the offset, and the bits above the access size are zero.
- R6: With latch bit 31 clear, accesses to the data window are passed through and issue no request.
- R7: With scheme two strapped, a byte access to 0xCF8 reads and writes the enable byte and a byte access to 0xCFA reads and writes the bus byte. Writing 0 to the enable byte reads back 0.
- R8: When enable bit 7 is set, an aligned access to 0xC000 | dev<<8 | reg issues a request with device = address[11:8], register = address[7:2], function = enable[3:1] and bus = bus byte. cfg_type1_o is 1 exactly when the bus byte is nonzero. When enable bit 7 is clear, these addresses are passed through.
- R9: A read answered with cfg_err_i=1 returns all ones within the access size.
- R10: A request left unacknowledged completes after exactly TIMEOUT_CYC cycles of cfg_req_o. A read completed this way returns all ones.
- R11: Each accepted access gives one io_done_o pulse. Requests that arrive while a configuration request is pending are ignored, and io_done_o is never high together with cfg_req_o.
- R12: With both straps set, a dword at 0xCF8 reaches the latch and a byte at 0xCF8 reaches the enable byte. The scheme-one window takes priority in the data window.
- R13: While cfg_req_o stays high, every request field stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode1_en_i | input | 1 | Strap: latch-and-window scheme live |
| mode2_en_i | input | 1 | Strap: paged-window scheme live |
| io_req_i | input | 1 | I/O access request, one cycle |
| io_wr_i | input | 1 | 1 = write |
| io_addr_i | input | 16 | I/O byte address |
| io_size_i | input | 2 | 0 byte, 1 half, 2 dword |
| io_wdata_i | input | 32 | Write data, lane-0 justified |
| io_done_o | output | 1 | Access complete pulse |
| io_pass_o | output | 1 | Access not claimed, valid with done |
| io_rdata_o | output | 32 | Read data, lane-0 justified |
| cfg_req_o | output | 1 | Configuration request pending |
| cfg_wr_o | output | 1 | Request is a write |
| cfg_bus_o | output | 8 | Bus number |
| cfg_dev_o | output | 5 | Device number |
| cfg_fn_o | output | 3 | Function number |
| cfg_reg_o | output | 6 | Dword register index |
| cfg_be_o | output | 4 | Byte enables |
| cfg_type1_o | output | 1 | Type 1 cycle |
| cfg_wdata_o | output | 32 | Write data in byte lanes |
| cfg_ack_i | input | 1 | Target response valid |
| cfg_err_i | input | 1 | No target answered |
| cfg_rdata_i | input | 32 | Response data |

## Verification
Scheme one is tried with reads and writes of byte, half and dword size at every window offset, including misaligned ones. This separates correct lane selection and realignment from a fixed lane or a missing alignment check. Scheme two is tried with the window open on a nonzero bus and on bus zero, and with the window closed, which shows whether the cycle type and the gating by the enable bit are right. Error, timeout and overlapping-request patterns show that absent targets read as ones and that a pending cycle blocks new accesses. Dual-strap runs show the priority between the latch and the enable byte.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam int DW  = 32;
  localparam int BEW = DW / 8;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} io_sz_e;

  typedef struct packed {
    logic           wr;
    logic [7:0]     bus;
    logic [4:0]     dev;
    logic [2:0]     fn;
    logic [5:0]     rg;
    logic [BEW-1:0] be;
    logic           type1;
    logic [DW-1:0]  wdata;
  } cfg_cmd_t;

  function automatic logic [DW-1:0] rd_align(input logic [DW-1:0] d,
                                             input logic [1:0] off,
                                             input logic [1:0] sz);
    logic [DW-1:0] s;
    s = d >> {off, 3'b000};
    case (sz)
      SZ_BYTE: rd_align = {24'b0, s[7:0]};
      SZ_HALF: rd_align = {16'b0, s[15:0]};
      default: rd_align = s;
    endcase
  endfunction
endpackage

// File: rtl/cfg_port_lanes.sv
module cfg_port_lanes
  import cfg_port_pkg::*;
(
  input  logic [1:0]     off_i,
  input  logic [1:0]     sz_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [BEW-1:0] be_o,
  output logic [DW-1:0]  wdata_o,
  output logic           ok_o
);
  logic [2:0] nb;
  logic [2:0] lo;

  always_comb begin
    case (sz_i)
      SZ_BYTE: nb = 3'd1;
      SZ_HALF: nb = 3'd2;
      SZ_WORD: nb = 3'd4;
      default: nb = 3'd0;
    endcase
    ok_o = (sz_i == SZ_BYTE) ||
           (sz_i == SZ_HALF && !off_i[0]) ||
           (sz_i == SZ_WORD && off_i == 2'd0);
    lo = {1'b0, off_i};
    wdata_o = wdata_i << {off_i, 3'b000};
  end

  genvar j;
  generate
    for (j = 0; j < BEW; j++) begin : g_lane
      assign be_o[j] = ok_o && (3'(j) >= lo) && (3'(j) < lo + nb);
    end
  endgenerate
endmodule

// File: rtl/cfg_port_regs.sv
module cfg_port_regs
  import cfg_port_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_latch_i,
  input  logic          wr_en_i,
  input  logic          wr_fwd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] latch_o,
  output logic [7:0]    en_o,
  output logic [7:0]    fwd_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_o <= '0;
      en_o    <= '0;
      fwd_o   <= '0;
    end else begin
      if (wr_latch_i) latch_o <= wdata_i;
      if (wr_en_i)    en_o    <= wdata_i[7:0];
      if (wr_fwd_i)   fwd_o   <= wdata_i[7:0];
    end
  end
endmodule

// File: rtl/cfg_port_decode.sv
module cfg_port_decode
  import cfg_port_pkg::*;
(
  input  logic          m1_i,
  input  logic          m2_i,
  input  logic          wr_i,
  input  logic [15:0]   addr_i,
  input  logic [1:0]    sz_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] latch_i,
  input  logic [7:0]    en_i,
  input  logic [7:0]    fwd_i,
  output logic          hit_latch_o,
  output logic          hit_en_o,
  output logic          hit_fwd_o,
  output logic          hit_cfg_o,
  output logic [DW-1:0] reg_rdata_o,
  output cfg_cmd_t      cmd_o
);
  localparam logic [15:0] PORT_SEL  = 16'h0CF8;
  localparam logic [15:0] PORT_BUS  = 16'h0CFA;
  localparam logic [13:0] WIN_DWORD = 14'h033F; // 0xCFC >> 2
  localparam logic [3:0]  PAGE_HI   = 4'hC;

  logic [BEW-1:0] be;
  logic [DW-1:0]  wsh;
  logic           ok, reg_hit, win1, win2;

  cfg_port_lanes u_lanes (
    .off_i   (addr_i[1:0]),
    .sz_i    (sz_i),
    .wdata_i (wdata_i),
    .be_o    (be),
    .wdata_o (wsh),
    .ok_o    (ok)
  );

  always_comb begin
    hit_latch_o = m1_i && addr_i == PORT_SEL && sz_i == SZ_WORD;
    hit_en_o    = m2_i && addr_i == PORT_SEL && sz_i == SZ_BYTE;
    hit_fwd_o   = m2_i && addr_i == PORT_BUS && sz_i == SZ_BYTE;
    reg_hit     = hit_latch_o || hit_en_o || hit_fwd_o;
    win1        = m1_i && latch_i[31] && addr_i[15:2] == WIN_DWORD && ok && !reg_hit;
    win2        = m2_i && en_i[7] && addr_i[15:12] == PAGE_HI && ok && !reg_hit && !win1;
    hit_cfg_o   = win1 || win2;

    if (hit_latch_o)   reg_rdata_o = latch_i;
    else if (hit_en_o) reg_rdata_o = {24'b0, en_i};
    else               reg_rdata_o = {24'b0, fwd_i};

    cmd_o.wr    = wr_i;
    cmd_o.be    = be;
    cmd_o.wdata = wsh;
    if (win1) begin
      cmd_o.bus   = latch_i[23:16];
      cmd_o.dev   = latch_i[15:11];
      cmd_o.fn    = latch_i[10:8];
      cmd_o.rg    = latch_i[7:2];
      cmd_o.type1 = latch_i[0];
    end else begin
      cmd_o.bus   = fwd_i;
      cmd_o.dev   = {1'b0, addr_i[11:8]};
      cmd_o.fn    = en_i[3:1];
      cmd_o.rg    = addr_i[7:2];
      cmd_o.type1 = fwd_i != 8'd0;
    end
  end
endmodule

// File: rtl/cfg_port_seq.sv
module cfg_port_seq
  import cfg_port_pkg::*;
#(
  parameter int TIMEOUT_CYC = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fire_i,
  input  logic          hit_reg_i,
  input  logic          hit_cfg_i,
  input  logic          wr_i,
  input  logic [DW-1:0] reg_rdata_i,
  input  cfg_cmd_t      cmd_i,
  input  logic [1:0]    off_i,
  input  logic [1:0]    sz_i,
  input  logic          ack_i,
  input  logic          err_i,
  input  logic [DW-1:0] rsp_i,
  output logic          idle_o,
  output logic          done_o,
  output logic          pass_o,
  output logic [DW-1:0] rdata_o,
  output logic          req_o,
  output cfg_cmd_t      cmd_o
);
  localparam int TMR_W = $clog2(TIMEOUT_CYC + 1);

  typedef enum logic {S_IDLE, S_WAIT} st_e;
  st_e             st_q;
  logic [TMR_W-1:0] tmr_q;
  logic [1:0]       off_q, sz_q;
  logic             expire;

  assign idle_o = st_q == S_IDLE;
  assign expire = tmr_q == TMR_W'(TIMEOUT_CYC - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      tmr_q   <= '0;
      off_q   <= '0;
      sz_q    <= '0;
      done_o  <= 1'b0;
      pass_o  <= 1'b0;
      rdata_o <= '0;
      req_o   <= 1'b0;
      cmd_o   <= '0;
    end else begin
      done_o <= 1'b0;
      pass_o <= 1'b0;
      case (st_q)
        S_IDLE: if (fire_i) begin
          if (hit_cfg_i) begin
            req_o <= 1'b1;
            cmd_o <= cmd_i;
            off_q <= off_i;
            sz_q  <= sz_i;
            tmr_q <= '0;
            st_q  <= S_WAIT;
          end else begin
            done_o  <= 1'b1;
            pass_o  <= !hit_reg_i;
            rdata_o <= (hit_reg_i && !wr_i) ? reg_rdata_i : '0;
          end
        end
        S_WAIT: if (ack_i || expire) begin
          req_o   <= 1'b0;
          done_o  <= 1'b1;
          st_q    <= S_IDLE;
          if (cmd_o.wr)              rdata_o <= '0;
          else if (ack_i && !err_i)  rdata_o <= rd_align(rsp_i, off_q, sz_q);
          else                       rdata_o <= rd_align('1, off_q, sz_q);
        end else begin
          tmr_q <= tmr_q + 1'b1;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_port_xlat.sv
module cfg_port_xlat
  import cfg_port_pkg::*;
#(
  parameter int TIMEOUT_CYC = 64
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        mode1_en_i,
  input  logic        mode2_en_i,
  input  logic        io_req_i,
  input  logic        io_wr_i,
  input  logic [15:0] io_addr_i,
  input  logic [1:0]  io_size_i,
  input  logic [31:0] io_wdata_i,
  output logic        io_done_o,
  output logic        io_pass_o,
  output logic [31:0] io_rdata_o,
  output logic        cfg_req_o,
  output logic        cfg_wr_o,
  output logic [7:0]  cfg_bus_o,
  output logic [4:0]  cfg_dev_o,
  output logic [2:0]  cfg_fn_o,
  output logic [5:0]  cfg_reg_o,
  output logic [3:0]  cfg_be_o,
  output logic        cfg_type1_o,
  output logic [31:0] cfg_wdata_o,
  input  logic        cfg_ack_i,
  input  logic        cfg_err_i,
  input  logic [31:0] cfg_rdata_i
);
  logic [DW-1:0] latch, reg_rdata;
  logic [7:0]    en, fwd;
  logic          hit_latch, hit_en, hit_fwd, hit_cfg, idle, fire;
  cfg_cmd_t      dec_cmd, cmd_q;

  assign fire = io_req_i && idle;

  cfg_port_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_latch_i (fire && io_wr_i && hit_latch),
    .wr_en_i    (fire && io_wr_i && hit_en),
    .wr_fwd_i   (fire && io_wr_i && hit_fwd),
    .wdata_i    (io_wdata_i),
    .latch_o    (latch),
    .en_o       (en),
    .fwd_o      (fwd)
  );

  cfg_port_decode u_dec (
    .m1_i        (mode1_en_i),
    .m2_i        (mode2_en_i),
    .wr_i        (io_wr_i),
    .addr_i      (io_addr_i),
    .sz_i        (io_size_i),
    .wdata_i     (io_wdata_i),
    .latch_i     (latch),
    .en_i        (en),
    .fwd_i       (fwd),
    .hit_latch_o (hit_latch),
    .hit_en_o    (hit_en),
    .hit_fwd_o   (hit_fwd),
    .hit_cfg_o   (hit_cfg),
    .reg_rdata_o (reg_rdata),
    .cmd_o       (dec_cmd)
  );

  cfg_port_seq #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fire_i      (fire),
    .hit_reg_i   (hit_latch || hit_en || hit_fwd),
    .hit_cfg_i   (hit_cfg),
    .wr_i        (io_wr_i),
    .reg_rdata_i (reg_rdata),
    .cmd_i       (dec_cmd),
    .off_i       (io_addr_i[1:0]),
    .sz_i        (io_size_i),
    .ack_i       (cfg_ack_i),
    .err_i       (cfg_err_i),
    .rsp_i       (cfg_rdata_i),
    .idle_o      (idle),
    .done_o      (io_done_o),
    .pass_o      (io_pass_o),
    .rdata_o     (io_rdata_o),
    .req_o       (cfg_req_o),
    .cmd_o       (cmd_q)
  );

  assign cfg_wr_o    = cmd_q.wr;
  assign cfg_bus_o   = cmd_q.bus;
  assign cfg_dev_o   = cmd_q.dev;
  assign cfg_fn_o    = cmd_q.fn;
  assign cfg_reg_o   = cmd_q.rg;
  assign cfg_be_o    = cmd_q.be;
  assign cfg_type1_o = cmd_q.type1;
  assign cfg_wdata_o = cmd_q.wdata;
endmodule

// File: rtl/cfg_port_xlat_chk.sv
module cfg_port_xlat_chk #(
  parameter int TIMEOUT_CYC = 64
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        io_done_o,
  input logic [7:0]  io_rdata_lo,
  input logic        cfg_req_o,
  input logic        cfg_wr_o,
  input logic [7:0]  cfg_bus_o,
  input logic [4:0]  cfg_dev_o,
  input logic [2:0]  cfg_fn_o,
  input logic [5:0]  cfg_reg_o,
  input logic [3:0]  cfg_be_o,
  input logic        cfg_type1_o,
  input logic [31:0] cfg_wdata_o,
  input logic        cfg_ack_i,
  input logic        cfg_err_i
);
  localparam int CW = $clog2(TIMEOUT_CYC + 2);
  logic [CW-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hold_q <= '0;
    else if (cfg_req_o) hold_q <= hold_q + 1'b1;
    else                hold_q <= '0;
  end

  always @(posedge clk_i)
    if (!rst_ni) assert_reset_quiet_R1: assert (!cfg_req_o && !io_done_o);

  assert_be_shape_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_req_o) |-> ($countones(cfg_be_o) == 1 || cfg_be_o == 4'b0011 ||
                          cfg_be_o == 4'b1100 || cfg_be_o == 4'b1111));

  assert_err_ones_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o && cfg_ack_i && cfg_err_i && !cfg_wr_o |=> io_done_o && io_rdata_lo == 8'hFF);

  assert_timeout_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_q <= CW'(TIMEOUT_CYC));

  assert_done_apart_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_req_o && io_done_o));

  assert_fields_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o && $past(cfg_req_o) |->
      $stable({cfg_wr_o, cfg_bus_o, cfg_dev_o, cfg_fn_o, cfg_reg_o, cfg_be_o,
               cfg_type1_o, cfg_wdata_o}));
endmodule

bind cfg_port_xlat cfg_port_xlat_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .io_done_o   (io_done_o),
  .io_rdata_lo (io_rdata_o[7:0]),
  .cfg_req_o   (cfg_req_o),
  .cfg_wr_o    (cfg_wr_o),
  .cfg_bus_o   (cfg_bus_o),
  .cfg_dev_o   (cfg_dev_o),
  .cfg_fn_o    (cfg_fn_o),
  .cfg_reg_o   (cfg_reg_o),
  .cfg_be_o    (cfg_be_o),
  .cfg_type1_o (cfg_type1_o),
  .cfg_wdata_o (cfg_wdata_o),
  .cfg_ack_i   (cfg_ack_i),
  .cfg_err_i   (cfg_err_i)
);

// File: tb/cfg_port_xlat_test.sv
module cfg_port_xlat_test;
  localparam int TMO = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m1 = 1'b1, m2 = 1'b0;
  logic        io_req = 1'b0, io_wr = 1'b0;
  logic [15:0] io_addr = '0;
  logic [1:0]  io_size = '0;
  logic [31:0] io_wdata = '0;
  logic        io_done, io_pass;
  logic [31:0] io_rdata;
  logic        cfg_req, cfg_wr, cfg_type1;
  logic [7:0]  cfg_bus;
  logic [4:0]  cfg_dev;
  logic [2:0]  cfg_fn;
  logic [5:0]  cfg_reg;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic        cfg_ack = 1'b0, cfg_err = 1'b0;
  logic [31:0] cfg_rdata = '0;

  always #10 clk = ~clk;

  cfg_port_xlat #(.TIMEOUT_CYC(TMO)) uut (
    .clk_i(clk), .rst_ni(rst_n), .mode1_en_i(m1), .mode2_en_i(m2),
    .io_req_i(io_req), .io_wr_i(io_wr), .io_addr_i(io_addr), .io_size_i(io_size),
    .io_wdata_i(io_wdata), .io_done_o(io_done), .io_pass_o(io_pass),
    .io_rdata_o(io_rdata), .cfg_req_o(cfg_req), .cfg_wr_o(cfg_wr),
    .cfg_bus_o(cfg_bus), .cfg_dev_o(cfg_dev), .cfg_fn_o(cfg_fn),
    .cfg_reg_o(cfg_reg), .cfg_be_o(cfg_be), .cfg_type1_o(cfg_type1),
    .cfg_wdata_o(cfg_wdata), .cfg_ack_i(cfg_ack), .cfg_err_i(cfg_err),
    .cfg_rdata_i(cfg_rdata)
  );

  typedef struct {
    logic [31:0] rdata;
    logic        pass;
    string       tag;
  } io_exp_t;

  typedef struct {
    logic [57:0] f;
    string       tag;
  } cfg_exp_t;

  io_exp_t  io_q[$];
  cfg_exp_t cfg_q[$];
  int total = 0, bad = 0;
  int tmo_cnt = 0, dly = 0;
  bit cfg_seen = 0, finished = 0;

  function automatic logic [31:0] model(input logic [7:0] b, input logic [4:0] d,
                                        input logic [2:0] f, input logic [5:0] r);
    model = {b, 3'b0, d, 5'b0, f, 2'b0, r};
  endfunction

  function automatic logic [31:0] mk(input logic [7:0] b, input logic [4:0] d,
                                     input logic [2:0] f, input logic [5:0] r,
                                     input logic [1:0] t);
    mk = {1'b1, 7'b0, b, d, f, r, t};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor and target responder
  always @(negedge clk) begin
    if (cfg_ack) begin
      cfg_ack = 1'b0;
      cfg_err = 1'b0;
    end else if (cfg_req && cfg_dev != 5'd9) begin
      if (dly == 2) begin
        cfg_ack = 1'b1;
        cfg_err = cfg_dev == 5'd7;
        cfg_rdata = model(cfg_bus, cfg_dev, cfg_fn, cfg_reg);
        dly = 0;
      end else dly++;
    end else dly = 0;

    if (cfg_req) tmo_cnt++;
    if (cfg_req && !cfg_seen) begin
      logic [57:0] got;
      cfg_seen = 1;
      tmo_cnt = 1;
      got = {cfg_wr, cfg_bus, cfg_dev, cfg_fn, cfg_reg, cfg_be, cfg_type1, cfg_wdata};
      if (cfg_q.size() == 0) chk(0, "R6 unexpected request", 64'(got), 64'd0);
      else begin
        cfg_exp_t e;
        e = cfg_q.pop_front();
        chk(got == e.f, e.tag, 64'(got), 64'(e.f));
      end
    end
    if (!cfg_req) cfg_seen = 0;

    if (io_done) begin
      if (io_q.size() == 0) chk(0, "R11 extra done", 64'(io_rdata), 64'd0);
      else begin
        io_exp_t e;
        e = io_q.pop_front();
        chk(io_rdata == e.rdata && io_pass == e.pass, e.tag,
            {31'b0, io_pass, io_rdata}, {31'b0, e.pass, e.rdata});
      end
    end
  end

  task automatic exp_cfg(input logic wr, input logic [7:0] b, input logic [4:0] d,
                         input logic [2:0] f, input logic [5:0] r, input logic [3:0] be,
                         input logic t1, input logic [31:0] wd, input string tag);
    cfg_exp_t e;
    e.f = {wr, b, d, f, r, be, t1, wd};
    e.tag = tag;
    cfg_q.push_back(e);
  endtask

  task automatic io_op(input logic wr, input logic [15:0] a, input logic [1:0] sz,
                       input logic [31:0] wd, input logic [31:0] er, input logic ep,
                       input string tag);
    io_exp_t e;
    e.rdata = er; e.pass = ep; e.tag = tag;
    io_q.push_back(e);
    @(negedge clk);
    io_req = 1'b1; io_wr = wr; io_addr = a; io_size = sz; io_wdata = wd;
    @(negedge clk);
    io_req = 1'b0;
    while (io_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] la, w;
    repeat (3) @(negedge clk);
    chk(!cfg_req && !io_done, "R1 outputs quiet in reset", {cfg_req, io_done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cfg_req && !io_done, "R1 outputs quiet after reset", {cfg_req, io_done}, 0);
    io_op(0, 16'h0CF8, 2, 0, 32'h0, 0, "R1 latch zero after reset");

    la = mk(8'h12, 5'd20, 3'd5, 6'd9, 2'b01);
    io_op(1, 16'h0CF8, 2, la, 0, 0, "R2 latch write");
    io_op(0, 16'h0CF8, 2, 0, la, 0, "R2 latch readback");

    w = model(8'h12, 5'd20, 3'd5, 6'd9);
    exp_cfg(0, 8'h12, 5'd20, 3'd5, 6'd9, 4'b1111, 1, 0, "R4 dword read fields");
    io_op(0, 16'h0CFC, 2, 0, w, 0, "R4 dword read data");
    exp_cfg(0, 8'h12, 5'd20, 3'd5, 6'd9, 4'b0100, 1, 0, "R5 byte lane 2");
    io_op(0, 16'h0CFE, 0, 0, {24'b0, w[23:16]}, 0, "R5 byte read realigned");
    exp_cfg(0, 8'h12, 5'd20, 3'd5, 6'd9, 4'b0010, 1, 0, "R5 byte lane 1");
    io_op(0, 16'h0CFD, 0, 0, {24'b0, w[15:8]}, 0, "R5 byte read lane 1");
    exp_cfg(1, 8'h12, 5'd20, 3'd5, 6'd9, 4'b1100, 1, 32'hBEEF0000, "R4 half write shift");
    io_op(1, 16'h0CFE, 1, 32'h0000BEEF, 0, 0, "R4 half write done");
    exp_cfg(1, 8'h12, 5'd20, 3'd5, 6'd9, 4'b1000, 1, 32'h5A000000, "R5 byte lane 3 write");
    io_op(1, 16'h0CFF, 0, 32'h5A, 0, 0, "R5 byte write done");
    exp_cfg(0, 8'h12, 5'd20, 3'd5, 6'd9, 4'b0011, 1, 0, "R5 half lane 0");
    io_op(0, 16'h0CFC, 1, 0, {16'b0, w[15:0]}, 0, "R5 half read");
    io_op(0, 16'h0CFD, 1, 0, 0, 1, "R5 misaligned half passes");
    io_op(0, 16'h0CFE, 2, 0, 0, 1, "R5 misaligned dword passes");

    io_op(1, 16'h0CF8, 0, 32'h77, 0, 1, "R3 byte at latch passes");
    io_op(0, 16'h0CFA, 1, 0, 0, 1, "R3 half at latch passes");
    io_op(0, 16'h0CF8, 2, 0, la, 0, "R3 latch unchanged");

    io_op(1, 16'h0CF8, 2, 0, 0, 0, "R2 write zero");
    io_op(0, 16'h0CF8, 2, 0, 0, 0, "R2 zero readback");
    io_op(0, 16'h0CFC, 0, 0, 0, 1, "R6 window closed passes");

    io_op(1, 16'h0CF8, 2, mk(8'h00, 5'd3, 3'd0, 6'd0, 2'b00), 0, 0, "R4 bus0 latch");
    exp_cfg(0, 8'h00, 5'd3, 3'd0, 6'd0, 4'b1111, 0, 0, "R4 type0 on bus 0");
    io_op(0, 16'h0CFC, 2, 0, model(8'h00, 5'd3, 3'd0, 6'd0), 0, "R4 bus0 read");

    io_op(1, 16'h0CF8, 2, mk(8'h01, 5'd7, 3'd2, 6'd4, 2'b01), 0, 0, "R9 latch");
    exp_cfg(0, 8'h01, 5'd7, 3'd2, 6'd4, 4'b1111, 1, 0, "R9 request");
    io_op(0, 16'h0CFC, 2, 0, 32'hFFFFFFFF, 0, "R9 absent dword ones");
    exp_cfg(0, 8'h01, 5'd7, 3'd2, 6'd4, 4'b0010, 1, 0, "R9 request byte");
    io_op(0, 16'h0CFD, 0, 0, 32'h000000FF, 0, "R9 absent byte ones");

    la = mk(8'h02, 5'd9, 3'd1, 6'd2, 2'b01);
    io_op(1, 16'h0CF8, 2, la, 0, 0, "R10 latch");
    exp_cfg(0, 8'h02, 5'd9, 3'd1, 6'd2, 4'b1111, 1, 0, "R10 request");
    io_op(0, 16'h0CFC, 2, 0, 32'hFFFFFFFF, 0, "R10 timeout ones");
    chk(tmo_cnt == TMO, "R10 timeout length", 64'(tmo_cnt), 64'(TMO));

    // R11: second request during a pending cycle is dropped
    begin
      io_exp_t e;
      e.rdata = 0; e.pass = 0; e.tag = "R11 pending write completes";
      io_q.push_back(e);
      exp_cfg(1, 8'h02, 5'd9, 3'd1, 6'd2, 4'b1111, 1, 32'h1234, "R11 request");
      @(negedge clk);
      io_req = 1; io_wr = 1; io_addr = 16'h0CFC; io_size = 2; io_wdata = 32'h1234;
      @(negedge clk);
      io_req = 0;
      @(negedge clk);
      io_req = 1; io_wr = 1; io_addr = 16'h0CF8; io_size = 2; io_wdata = 0;
      @(negedge clk);
      io_req = 0;
      while (io_q.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
    end
    io_op(0, 16'h0CF8, 2, 0, la, 0, "R11 overlapped write ignored");

    m1 = 1'b0; m2 = 1'b1;
    io_op(1, 16'h0CF8, 0, 32'h86, 0, 0, "R7 enable write");
    io_op(0, 16'h0CF8, 0, 0, 32'h86, 0, "R7 enable readback");
    io_op(1, 16'h0CFA, 0, 32'h05, 0, 0, "R7 bus write");
    io_op(0, 16'h0CFA, 0, 0, 32'h05, 0, "R7 bus readback");
    exp_cfg(0, 8'h05, 5'd3, 3'd3, 6'd4, 4'b1111, 1, 0, "R8 paged request");
    io_op(0, 16'hC310, 2, 0, model(8'h05, 5'd3, 3'd3, 6'd4), 0, "R8 paged read");
    exp_cfg(1, 8'h05, 5'd7, 3'd3, 6'd0, 4'b0100, 1, 32'h00AB0000, "R8 paged byte write");
    io_op(1, 16'hC702, 0, 32'hAB, 0, 0, "R8 paged write done");
    io_op(1, 16'h0CFA, 0, 0, 0, 0, "R8 bus zero");
    exp_cfg(0, 8'h00, 5'd0, 3'd3, 6'd0, 4'b1100, 0, 0, "R8 type0 on bus 0");
    io_op(0, 16'hC002, 1, 0, {16'b0, model(8'h00, 5'd0, 3'd3, 6'd0) >> 16}, 0, "R8 half read");
    io_op(1, 16'h0CF8, 0, 0, 0, 0, "R7 close window");
    io_op(0, 16'h0CF8, 0, 0, 0, 0, "R7 zero readback");
    io_op(0, 16'hC310, 2, 0, 0, 1, "R8 closed window passes");

    m1 = 1'b1; m2 = 1'b1;
    la = mk(8'h21, 5'd4, 3'd6, 6'd1, 2'b01);
    io_op(1, 16'h0CF8, 2, la, 0, 0, "R12 dword to latch");
    io_op(1, 16'h0CF8, 0, 32'h80, 0, 0, "R12 byte to enable");
    io_op(0, 16'h0CF8, 2, 0, la, 0, "R12 latch kept");
    io_op(0, 16'h0CF8, 0, 0, 32'h80, 0, "R12 enable kept");
    exp_cfg(0, 8'h21, 5'd4, 3'd6, 6'd1, 4'b1111, 1, 0, "R12 latch window priority");
    io_op(0, 16'h0CFC, 2, 0, model(8'h21, 5'd4, 3'd6, 6'd1), 0, "R12 priority read");

    repeat (4) @(negedge clk);
    chk(cfg_q.size() == 0, "R13 all requests seen", 64'(cfg_q.size()), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule